// File: doc/BRIEF.md
# Position Output Latch with Inhibit and Byte-Lane Bus Drive

This block sits between a free-running up/down position counter and a host data bus that may be 8 or 16 bits wide. While the hold input is released, a holding register follows the counter on every cycle in which the counter reports no update in progress. When the host pulls the hold input low, the register stops loading and the counter keeps tracking. Once the hold has lasted a set number of quiet cycles, a data-valid flag tells the host that the frozen word can be read. When the hold is released, the block adds a one-cycle update pulse to the busy output and forces a fresh load of the holding register, so the host-visible word catches up with the counter.

The held word is presented on two 8-bit output lanes. Each output line is modelled as a data bit plus a drive-enable bit, so a bus can be tri-stated outside the block. Lane B always carries the low byte. Lane A carries the high byte or the low byte, chosen by a byte-select input. An 8-bit host reads both bytes over lane A, and a 16-bit host reads lane A and lane B together. A resolution select picks 10, 12, 14 or 16 active bits, and every inactive bit reads as zero.

Top module: `pos_out_latch`

## Requirements
- R1: After reset the holding register is zero, busyOut is 0 and dataValid is 0, so an enabled bus shows 0x00 on both lanes.
- R2: While inhibitN is 1 and cntBusy is 0, the holding register takes the masked countIn at each rising clock edge.
- R3: While inhibitN is 0, the holding register keeps its value whatever countIn does.
- R4: While inhibitN is 1 and cntBusy is 1, the holding register keeps its value, except on the refresh edge described in R5.
- R5: On the first edge at which inhibitN is sampled 1 after being sampled 0, a one-cycle refresh starts. busyOut is high for that cycle (busyOut = cntBusy OR refresh). At the next edge the register loads countIn even if cntBusy is 1, provided inhibitN is still 1.
- R6: dataValid goes to 1 after VALID_CYC consecutive edges with inhibitN = 0 and cntBusy = 0. An edge with cntBusy = 1 restarts the count. An edge with inhibitN = 1 clears the flag.
- R7: With enableN = 1, every drive-enable bit of both lanes is 0 and both data lanes read 0x00. With enableN = 0, all 16 drive-enable bits are 1.
- R8: When enabled, lane B carries bits 7..0 of the held word whatever byteSel is.
- R9: When enabled, byteSel = 1 puts bits 15..8 of the held word on lane A, and byteSel = 0 puts bits 7..0 there, the same as lane B.
- R10: resSel selects the active width: 0 gives 10 bits, 1 gives 12, 2 gives 14 and 3 gives 16. Count bits at and above the active width are stored as 0.
- R11: enableN and byteSel have no effect on loading. A word loaded while the outputs are disabled appears once they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countIn | input | 16 | Current position counter value |
| resSel | input | 2 | Resolution select (0:10, 1:12, 2:14, 3:16 bits) |
| cntBusy | input | 1 | Counter update in progress |
| inhibitN | input | 1 | Hold request, active low, freezes the holding register |
| enableN | input | 1 | Output drive enable, active low |
| byteSel | input | 1 | Lane A byte choice: 1 high byte, 0 low byte |
| busyOut | output | 1 | Counter busy merged with the release refresh pulse |
| dataValid | output | 1 | Held word is stable and can be read |
| laneA | output | 8 | Lane A data (output lines 1 to 8) |
| laneAOe | output | 8 | Lane A drive enables |
| laneB | output | 8 | Lane B data (output lines 9 to 16) |
| laneBOe | output | 8 | Lane B drive enables |

## Verification
The assertions check these relations on every cycle: a frozen word never moves while the hold is applied, a release is always followed by a busy cycle, the valid flag drops after any busy or released edge, disabled lanes never drive, lane B always shows the low byte, and a 10-bit load never sets the upper bits. Some behaviours depend on a sequence of events, and only the bench's scenarios can show them. These are the exact cycle at which dataValid rises after a quiet hold, the forced reload while the counter is busy during a release, the masking at each of the four resolutions, and a word loaded while the outputs were disabled showing up once they are enabled.

// File: rtl/pos_out_pkg.sv
package pos_out_pkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 2 * LANE_W;
  localparam int RES_STEP = 2;

  typedef struct packed {
    logic load;
    logic refresh;
  } posStrobeT;
endpackage

// File: rtl/pos_out_ctrl.sv
module pos_out_ctrl #(
  parameter int VALID_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inhibitN,
  input  logic                   cntBusy,
  output pos_out_pkg::posStrobeT strobes,
  output logic                   busyOut,
  output logic                   dataValid
);
  localparam int CW = $clog2(VALID_CYC + 1);
  localparam logic [CW-1:0] VALID_Q = CW'(VALID_CYC);

  logic          inhPrev;
  logic          refreshQ;
  logic [CW-1:0] quietCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inhPrev  <= 1'b1;
      refreshQ <= 1'b0;
      quietCnt <= '0;
    end else begin
      inhPrev  <= inhibitN;
      refreshQ <= inhibitN & ~inhPrev;
      if (inhibitN || cntBusy) begin
        quietCnt <= '0;
      end else if (quietCnt != VALID_Q) begin
        quietCnt <= quietCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.refresh = refreshQ;
    strobes.load    = inhibitN & (refreshQ | ~cntBusy);
  end

  assign busyOut   = cntBusy | refreshQ;
  assign dataValid = (quietCnt == VALID_Q);

  // R5: a release of the hold produces a busy cycle next
  a_r5_release_busy: assert property (@(posedge clk) disable iff (!rstN)
    (inhibitN && !inhPrev) |=> busyOut);
  // R6: a busy or released edge leaves the valid flag low
  a_r6_valid_drop: assert property (@(posedge clk) disable iff (!rstN)
    (inhibitN || cntBusy) |=> !dataValid);
endmodule

// File: rtl/pos_out_datapath.sv
module pos_out_datapath
  import pos_out_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  posStrobeT         strobes,
  input  logic [WORD_W-1:0] countIn,
  input  logic [1:0]        resSel,
  output logic [WORD_W-1:0] latchWord
);
  localparam int MIN_BITS = WORD_W - 3 * RES_STEP;

  int                activeBits;
  logic [WORD_W-1:0] keepMask;
  logic [WORD_W-1:0] maskedCount;

  assign activeBits = MIN_BITS + RES_STEP * int'(resSel);

  for (genvar b = 0; b < WORD_W; b++) begin : g_mask
    assign keepMask[b] = (b < activeBits);
  end

  assign maskedCount = countIn & keepMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchWord <= '0;
    end else if (strobes.load) begin
      latchWord <= maskedCount;
    end
  end

  // R5: a refresh load captures the current count
  a_r5_refresh_capture: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.refresh && strobes.load) |=> (latchWord == $past(maskedCount)));
  // R10: at the narrowest resolution the upper bits stay clear
  a_r10_narrow_mask: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && resSel == 2'd0) |=> (latchWord[WORD_W-1:MIN_BITS] == '0));
endmodule

// File: rtl/pos_out_busmux.sv
module pos_out_busmux
  import pos_out_pkg::*;
(
  input  logic [WORD_W-1:0] latchWord,
  input  logic              enableN,
  input  logic              byteSel,
  output logic [LANE_W-1:0] laneA,
  output logic [LANE_W-1:0] laneAOe,
  output logic [LANE_W-1:0] laneB,
  output logic [LANE_W-1:0] laneBOe
);
  logic [LANE_W-1:0] hiByte;
  logic [LANE_W-1:0] loByte;

  assign hiByte = latchWord[WORD_W-1:LANE_W];
  assign loByte = latchWord[LANE_W-1:0];

  for (genvar i = 0; i < LANE_W; i++) begin : g_line
    assign laneAOe[i] = ~enableN;
    assign laneBOe[i] = ~enableN;
    assign laneA[i]   = ~enableN & (byteSel ? hiByte[i] : loByte[i]);
    assign laneB[i]   = ~enableN & loByte[i];
  end
endmodule

// File: rtl/pos_out_latch.sv
module pos_out_latch
  import pos_out_pkg::*;
#(
  parameter int VALID_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] countIn,
  input  logic [1:0]        resSel,
  input  logic              cntBusy,
  input  logic              inhibitN,
  input  logic              enableN,
  input  logic              byteSel,
  output logic              busyOut,
  output logic              dataValid,
  output logic [LANE_W-1:0] laneA,
  output logic [LANE_W-1:0] laneAOe,
  output logic [LANE_W-1:0] laneB,
  output logic [LANE_W-1:0] laneBOe
);
  posStrobeT         strobes;
  logic [WORD_W-1:0] latchWord;

  pos_out_ctrl #(.VALID_CYC(VALID_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .inhibitN(inhibitN), .cntBusy(cntBusy),
    .strobes(strobes), .busyOut(busyOut), .dataValid(dataValid)
  );

  pos_out_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .countIn(countIn),
    .resSel(resSel), .latchWord(latchWord)
  );

  pos_out_busmux u_mux (
    .latchWord(latchWord), .enableN(enableN), .byteSel(byteSel),
    .laneA(laneA), .laneAOe(laneAOe), .laneB(laneB), .laneBOe(laneBOe)
  );

  // R3: the held word does not move while the hold is applied
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !inhibitN |=> $stable(latchWord));
  // R7: disabled lanes never drive
  a_r7_hiz: assert property (@(posedge clk) disable iff (!rstN)
    enableN |-> ((laneAOe | laneBOe) == '0));
  // R8: lane B tracks the held low byte whenever driven
  a_r8_lane_b_low: assert property (@(posedge clk) disable iff (!rstN)
    !enableN |-> (laneB == latchWord[LANE_W-1:0]));
  // R9: with byteSel low both lanes match
  a_r9_dup_low: assert property (@(posedge clk) disable iff (!rstN)
    (!enableN && !byteSel) |-> (laneA == laneB));
endmodule

// File: tb/pos_out_latch_bench.sv
module pos_out_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VALID_CYC = 4;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [15:0] countIn = '0;
  logic [1:0] resSel = 2'd3;
  logic       cntBusy = 1'b0;
  logic       inhibitN = 1'b1;
  logic       enableN = 1'b0;
  logic       byteSel = 1'b1;
  logic       busyOut, dataValid;
  logic [7:0] laneA, laneAOe, laneB, laneBOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pos_out_latch #(.VALID_CYC(VALID_CYC)) u_pos_out_latch (
    .clk(clk), .rstN(rstN), .countIn(countIn), .resSel(resSel),
    .cntBusy(cntBusy), .inhibitN(inhibitN), .enableN(enableN),
    .byteSel(byteSel), .busyOut(busyOut), .dataValid(dataValid),
    .laneA(laneA), .laneAOe(laneAOe), .laneB(laneB), .laneBOe(laneBOe)
  );

  // {inhN, busy, enN, bsel, res[1:0], count[15:0], expA, expB, expOe, expBusy}
  localparam logic [39:0] VEC [NVEC] = '{
    {4'b1001, 2'd3, 16'hA5C3, 8'hA5, 8'hC3, 2'b10}, // R2 R9 high byte
    {4'b1000, 2'd3, 16'h1234, 8'h34, 8'h34, 2'b10}, // R8 R9 low byte dup
    {4'b1001, 2'd0, 16'hFFFF, 8'h03, 8'hFF, 2'b10}, // R10 10 bits
    {4'b1001, 2'd1, 16'hFFFF, 8'h0F, 8'hFF, 2'b10}, // R10 12 bits
    {4'b1001, 2'd2, 16'h9ABC, 8'h1A, 8'hBC, 2'b10}, // R10 14 bits
    {4'b1101, 2'd3, 16'h5555, 8'h1A, 8'hBC, 2'b11}, // R4 busy holds
    {4'b1011, 2'd3, 16'h7788, 8'h00, 8'h00, 2'b00}, // R7 disabled
    {4'b1001, 2'd3, 16'h7788, 8'h77, 8'h88, 2'b10}, // R11 loaded while off
    {4'b0000, 2'd3, 16'h0102, 8'h88, 8'h88, 2'b10}, // R3 frozen
    {4'b0001, 2'd3, 16'h0304, 8'h77, 8'h88, 2'b10}, // R3 frozen
    {4'b1001, 2'd3, 16'h0506, 8'h05, 8'h06, 2'b11}, // R5 release pulse
    {4'b1001, 2'd3, 16'h0506, 8'h05, 8'h06, 2'b10}  // R5 pulse ends
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1 reset state
    repeat (3) tick();
    chk("R1 laneA", {24'h0, laneA}, 32'h0);
    chk("R1 laneB", {24'h0, laneB}, 32'h0);
    chk("R1 busyOut", {31'h0, busyOut}, 32'h0);
    chk("R1 dataValid", {31'h0, dataValid}, 32'h0);
    rstN = 1'b1;
    tick();

    for (int i = 0; i < NVEC; i++) begin
      {inhibitN, cntBusy, enableN, byteSel} = VEC[i][39:36];
      resSel  = VEC[i][35:34];
      countIn = VEC[i][33:18];
      tick();
      chk($sformatf("vec%0d laneA R9", i), {24'h0, laneA}, {24'h0, VEC[i][17:10]});
      chk($sformatf("vec%0d laneB R8", i), {24'h0, laneB}, {24'h0, VEC[i][9:2]});
      chk($sformatf("vec%0d oe R7", i), {16'h0, laneAOe, laneBOe},
          VEC[i][1] ? 32'hFFFF : 32'h0);
      chk($sformatf("vec%0d busyOut R5", i), {31'h0, busyOut}, {31'h0, VEC[i][0]});
    end

    // R6 valid after VALID_CYC quiet held edges
    enableN = 1'b0; byteSel = 1'b1; cntBusy = 1'b0; inhibitN = 1'b0;
    repeat (VALID_CYC - 1) tick();
    chk("R6 not yet valid", {31'h0, dataValid}, 32'h0);
    tick();
    chk("R6 valid", {31'h0, dataValid}, 32'h1);
    cntBusy = 1'b1;
    tick();
    chk("R6 busy restarts", {31'h0, dataValid}, 32'h0);
    cntBusy = 1'b0;
    repeat (VALID_CYC - 1) tick();
    chk("R6 restart not yet", {31'h0, dataValid}, 32'h0);
    tick();
    chk("R6 valid again", {31'h0, dataValid}, 32'h1);

    // R5 forced reload while counter busy during release
    countIn = 16'hBEEF; cntBusy = 1'b1; inhibitN = 1'b1;
    tick();
    chk("R6 release clears", {31'h0, dataValid}, 32'h0);
    chk("R5 held through busy", {16'h0, laneA, laneB}, 32'h0506);
    chk("R5 busyOut", {31'h0, busyOut}, 32'h1);
    tick();
    chk("R5 forced reload", {16'h0, laneA, laneB}, 32'hBEEF);
    cntBusy = 1'b0; countIn = 16'h4321;
    tick();
    chk("R5 busy ends", {31'h0, busyOut}, 32'h0);
    chk("R2 follows", {16'h0, laneA, laneB}, 32'h4321);

    summary();
  end
endmodule